// File: doc/BRIEF.md
# PAM4 Test Symbol Encoder

The block produces one 2-bit PAM4 symbol per enabled clock cycle for transmitter and receiver test paths. The source is either a pseudo-random bit stream, taken two bits per symbol, or one of four fixed compliance-style sequences. Each symbol then passes through a configurable chain of transforms:
- polarity inversion of either bit,
- an optional Gray coder,
- an optional mod-4 precoder that implements 1/(1+D).

The inversion can be placed before or after the Gray coder.

A single-cycle request arms a one-shot error that corrupts the LSB, the MSB or both bits of the next emitted symbol. A marker output flags that symbol. The two bits leave on separate lanes. The MSB lane can be delayed by a programmable whole number of symbol periods, which emulates lane skew between the two bits.

Top module: `pam4_pattern_encoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first emitted symbol, `out_msb`, `out_lsb` and `err_mark` are 0.
- R2: A symbol is emitted only on a rising edge where `sym_en`=1 and `restart`=0. In other cycles, `out_lsb` and `err_mark` hold their values. `restart` has priority over `sym_en`: it emits nothing and returns the generator, the precoder state and any armed error to their initial state.
- R3: For `pat_sel` 0, 5, 6 or 7 the source is a bit stream with b[n] = b[n-1]^b[n-2]^b[n-12]^b[n-13]. The shift state is all ones after reset or restart. Each symbol takes two new bits: the first is the MSB and the second is the LSB.
- R4: With all transforms off, `pat_sel`=1 emits 0,3 repeated. `pat_sel`=3 emits eight 3s followed by eight 0s, repeated. A symbol value v appears as `out_msb`=v[1] and `out_lsb`=v[0].
- R5: `pat_sel`=2 emits a 62-symbol period: 0,3 fifteen times, then 3,0 sixteen times.
- R6: `pat_sel`=4 emits a 160-symbol period. The levels 0,1,2,3,0,3,0,3,2,1 follow in turn, each held for 16 symbols.
- R7: With `gray_en`=1, the bit pair {msb,lsb} maps to a level as follows: 00→0, 01→1, 11→2, 10→3.
- R8: `inv_msb` and `inv_lsb` flip their bit. With `inv_late`=0 the flip happens before the Gray coder. With `inv_late`=1 it happens after the Gray coder and before the precoder.
- R9: With `precode_en`=1, each emitted value is y=(x−p) mod 4, where p is the previous y. p is 0 after reset or restart, and it is updated only by symbols emitted with `precode_en`=1.
- R10: An `err_req` pulse with `err_mode`≠0 arms one error. If `sym_en` is high in the same cycle, the error applies to the symbol emitted in that cycle; otherwise it applies to the next emitted symbol.
  - `err_mode`=01 flips the LSB, 10 flips the MSB and 11 flips both.
  - `err_mode`=00 is ignored.
  - A newer request replaces the mode of an armed one.
  - Errors never enter the precoder state.
- R11: `err_mark` is 1 exactly while the output holds a symbol that was corrupted by R10.
- R12: `out_msb` carries the MSB of the symbol emitted `skew` emissions earlier. Values above MAX_SKEW (8) act as 8, and positions older than reset read 0. `out_lsb` is never delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Restart generator, precoder and armed error |
| sym_en | input | 1 | Emit one symbol this cycle |
| pat_sel | input | 3 | Source select (0 stream, 1 pair, 2 even-odd, 3 square, 4 staircase) |
| gray_en | input | 1 | Enable Gray coder |
| precode_en | input | 1 | Enable mod-4 precoder |
| inv_msb | input | 1 | Invert MSB |
| inv_lsb | input | 1 | Invert LSB |
| inv_late | input | 1 | Place inversion after the Gray coder |
| err_req | input | 1 | Single-cycle error request |
| err_mode | input | 2 | Error bits to flip (bit1 MSB, bit0 LSB) |
| skew | input | SKEW_W | MSB lane delay in symbols |
| out_msb | output | 1 | MSB lane |
| out_lsb | output | 1 | LSB lane |
| err_mark | output | 1 | Current symbol was corrupted |

## Verification
The properties take `err_req` to be a single-cycle strobe. They also take a change of `pat_sel` to happen only together with a `restart`, so that the sequence index never lies outside the new period. The stimulus changes the source only in restart cycles and holds each request for one cycle. It still issues requests in idle cycles, back to back and with mode 00. The skew property allows `skew` to move in the following cycle, so random skew changes stay legal.

// File: rtl/pam4_enc_pkg.sv
package pam4_enc_pkg;

  typedef logic [1:0] sym_t;

  typedef enum logic [2:0] {
    PAT_STREAM  = 3'd0,
    PAT_PAIR03  = 3'd1,
    PAT_EVENODD = 3'd2,
    PAT_SQUARE  = 3'd3,
    PAT_STAIR   = 3'd4
  } pat_e;

  localparam int PAIR_LEN      = 2;
  localparam int EVENODD_LEN   = 62;
  localparam int EVENODD_FIRST = 30;
  localparam int SQUARE_LEN    = 16;
  localparam int STAIR_HOLD    = 16;
  localparam int STAIR_STEPS   = 10;
  localparam int STAIR_LEN     = STAIR_HOLD * STAIR_STEPS;
  localparam int IDX_W         = $clog2(STAIR_LEN);
  localparam int HOLD_W        = $clog2(STAIR_HOLD);

  function automatic sym_t stair_level(input logic [IDX_W-HOLD_W-1:0] step);
    case (step)
      4'd0: stair_level = 2'd0;
      4'd1: stair_level = 2'd1;
      4'd2: stair_level = 2'd2;
      4'd3: stair_level = 2'd3;
      4'd4: stair_level = 2'd0;
      4'd5: stair_level = 2'd3;
      4'd6: stair_level = 2'd0;
      4'd7: stair_level = 2'd3;
      4'd8: stair_level = 2'd2;
      4'd9: stair_level = 2'd1;
      default: stair_level = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pam4_pat_src.sv
module pam4_pat_src
  import pam4_enc_pkg::*;
#(
  parameter int                LFSR_W    = 13,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 13'h1803
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       adv,
  input  logic [2:0] pat_sel,
  output sym_t       sym
);

  localparam logic [LFSR_W-1:0] SEED = '1;

  logic [LFSR_W-1:0] lfsr_q, lfsr_d, lfsr_s1, lfsr_s2;
  logic              bit_hi, bit_lo;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic              use_stream;
  sym_t              fixed_sym;

  // two stream bits per symbol, first one lands on the MSB
  always_comb begin
    bit_hi  = ^(lfsr_q & LFSR_TAPS);
    lfsr_s1 = {lfsr_q[LFSR_W-2:0], bit_hi};
    bit_lo  = ^(lfsr_s1 & LFSR_TAPS);
    lfsr_s2 = {lfsr_s1[LFSR_W-2:0], bit_lo};
  end

  always_comb begin
    use_stream = 1'b0;
    fixed_sym  = 2'd0;
    last_idx   = '0;
    case (pat_sel)
      PAT_PAIR03: begin
        fixed_sym = idx_q[0] ? 2'd3 : 2'd0;
        last_idx  = IDX_W'(PAIR_LEN - 1);
      end
      PAT_EVENODD: begin
        if (idx_q < IDX_W'(EVENODD_FIRST)) fixed_sym = idx_q[0] ? 2'd3 : 2'd0;
        else                               fixed_sym = idx_q[0] ? 2'd0 : 2'd3;
        last_idx = IDX_W'(EVENODD_LEN - 1);
      end
      PAT_SQUARE: begin
        fixed_sym = idx_q[HOLD_W-1] ? 2'd0 : 2'd3;
        last_idx  = IDX_W'(SQUARE_LEN - 1);
      end
      PAT_STAIR: begin
        fixed_sym = stair_level(idx_q[IDX_W-1:HOLD_W]);
        last_idx  = IDX_W'(STAIR_LEN - 1);
      end
      default: use_stream = 1'b1;
    endcase
  end

  assign sym = use_stream ? {bit_hi, bit_lo} : fixed_sym;

  always_comb begin
    lfsr_d = lfsr_q;
    idx_d  = idx_q;
    if (restart) begin
      lfsr_d = SEED;
      idx_d  = '0;
    end else if (adv) begin
      if (use_stream)              lfsr_d = lfsr_s2;
      else if (idx_q >= last_idx)  idx_d  = '0;
      else                         idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      idx_q  <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/pam4_sym_map.sv
module pam4_sym_map
  import pam4_enc_pkg::*;
(
  input  sym_t raw,
  input  logic gray_en,
  input  logic inv_msb,
  input  logic inv_lsb,
  input  logic inv_late,
  output sym_t mapped
);

  sym_t inv_mask, early, coded;

  always_comb begin
    inv_mask = {inv_msb, inv_lsb};
    early    = inv_late ? raw : (raw ^ inv_mask);
    coded    = gray_en ? {early[1], early[1] ^ early[0]} : early;
    mapped   = inv_late ? (coded ^ inv_mask) : coded;
  end

endmodule

// File: rtl/pam4_precoder.sv
module pam4_precoder
  import pam4_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic adv,
  input  logic enable,
  input  sym_t x,
  output sym_t y
);

  sym_t prev_q, prev_d;

  assign y = enable ? sym_t'(x - prev_q) : x;

  always_comb begin
    prev_d = prev_q;
    if (restart)             prev_d = 2'd0;
    else if (adv && enable)  prev_d = y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'd0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/pam4_lane_skew.sv
module pam4_lane_skew #(
  parameter int MAX_SKEW = 8,
  parameter int SKEW_W   = $clog2(MAX_SKEW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              cur,
  input  logic [SKEW_W-1:0] sel,
  output logic              out
);

  logic [MAX_SKEW:1] dly_q, dly_d;
  logic [MAX_SKEW:0] taps;
  logic [SKEW_W-1:0] sel_c;

  assign dly_d[1] = cur;
  for (genvar k = 2; k <= MAX_SKEW; k++) begin : g_stage
    assign dly_d[k] = dly_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dly_q <= '0;
    else if (adv) dly_q <= dly_d;
  end

  always_comb begin
    taps  = {dly_q, cur};
    sel_c = (sel > SKEW_W'(MAX_SKEW)) ? SKEW_W'(MAX_SKEW) : sel;
    out   = taps[sel_c];
  end

endmodule

// File: rtl/pam4_pattern_encoder.sv
module pam4_pattern_encoder
  import pam4_enc_pkg::*;
#(
  parameter int                LFSR_W    = 13,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 13'h1803,
  parameter int                MAX_SKEW  = 8,
  parameter int                SKEW_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              sym_en,
  input  logic [2:0]        pat_sel,
  input  logic              gray_en,
  input  logic              precode_en,
  input  logic              inv_msb,
  input  logic              inv_lsb,
  input  logic              inv_late,
  input  logic              err_req,
  input  logic [1:0]        err_mode,
  input  logic [SKEW_W-1:0] skew,
  output logic              out_msb,
  output logic              out_lsb,
  output logic              err_mark
);

  logic adv;
  sym_t raw, mapped, coded, word_d, flip;
  logic arm, pend_eff;
  logic [1:0] mode_eff;

  logic msb_cur, msb_d;
  logic lsb_q, lsb_d;
  logic mark_q, mark_d;
  logic pend_q, pend_d;
  logic [1:0] pmode_q, pmode_d;

  assign adv = sym_en & ~restart;

  pam4_pat_src #(
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS)
  ) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (adv),
    .pat_sel (pat_sel),
    .sym     (raw)
  );

  pam4_sym_map u_map (
    .raw      (raw),
    .gray_en  (gray_en),
    .inv_msb  (inv_msb),
    .inv_lsb  (inv_lsb),
    .inv_late (inv_late),
    .mapped   (mapped)
  );

  pam4_precoder u_prec (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (adv),
    .enable  (precode_en),
    .x       (mapped),
    .y       (coded)
  );

  // error arming and corruption, applied after the precoder tap
  always_comb begin
    arm      = err_req && (err_mode != 2'b00);
    pend_eff = pend_q | arm;
    mode_eff = arm ? err_mode : pmode_q;
    flip     = pend_eff ? mode_eff : 2'b00;
    word_d   = coded ^ flip;
  end

  always_comb begin
    msb_d   = msb_cur;
    lsb_d   = lsb_q;
    mark_d  = mark_q;
    pend_d  = pend_q;
    pmode_d = pmode_q;
    if (restart) begin
      pend_d = 1'b0;
    end else if (sym_en) begin
      msb_d  = word_d[1];
      lsb_d  = word_d[0];
      mark_d = pend_eff;
      pend_d = 1'b0;
    end else begin
      pend_d  = pend_eff;
      pmode_d = mode_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_cur <= 1'b0;
      lsb_q   <= 1'b0;
      mark_q  <= 1'b0;
      pend_q  <= 1'b0;
      pmode_q <= 2'b00;
    end else begin
      msb_cur <= msb_d;
      lsb_q   <= lsb_d;
      mark_q  <= mark_d;
      pend_q  <= pend_d;
      pmode_q <= pmode_d;
    end
  end

  pam4_lane_skew #(
    .MAX_SKEW (MAX_SKEW),
    .SKEW_W   (SKEW_W)
  ) u_skew (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .cur   (msb_cur),
    .sel   (skew),
    .out   (out_msb)
  );

  assign out_lsb  = lsb_q;
  assign err_mark = mark_q;

endmodule

// File: rtl/pam4_enc_checker.sv
module pam4_enc_checker #(
  parameter int SKEW_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              sym_en,
  input logic              err_req,
  input logic [1:0]        err_mode,
  input logic [SKEW_W-1:0] skew,
  input logic              out_msb,
  input logic              out_lsb,
  input logic              err_mark,
  input logic              msb_cur,
  input logic              pend_q
);

  // R2: nothing is emitted without an enable, and never in a restart cycle
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_en || restart) |=> ($stable(out_lsb) && $stable(err_mark) && $stable(msb_cur)));

  // R2: restart drops an armed error
  p_restart_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !pend_q);

  // R10: a mark appears only on an emission with an armed or fresh request
  p_mark_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_mark) |-> ($past(sym_en) && $past(pend_q || (err_req && err_mode != 2'b00))));

  // R11: an emission with nothing armed is never marked
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && !restart && !pend_q && !(err_req && err_mode != 2'b00)) |=> !err_mark);

  // R12: a one-symbol skew shows the previous MSB
  p_skew_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && !restart && skew == SKEW_W'(1)) |=>
      (skew != SKEW_W'(1) || out_msb == $past(msb_cur)));

endmodule

bind pam4_pattern_encoder pam4_enc_checker #(.SKEW_W(SKEW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .restart  (restart),
  .sym_en   (sym_en),
  .err_req  (err_req),
  .err_mode (err_mode),
  .skew     (skew),
  .out_msb  (out_msb),
  .out_lsb  (out_lsb),
  .err_mark (err_mark),
  .msb_cur  (msb_cur),
  .pend_q   (pend_q)
);

// File: tb/pam4_pattern_encoder_test.sv
module pam4_pattern_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXS       = 8;
  localparam int SW         = 4;

  logic clk = 1'b0;
  logic rst_n, restart, sym_en, gray_en, precode_en, inv_msb, inv_lsb, inv_late, err_req;
  logic [2:0] pat_sel;
  logic [1:0] err_mode;
  logic [SW-1:0] skew;
  logic out_msb, out_lsb, err_mark;

  int ncheck = 0;
  int nfail  = 0;

  // bench model state
  logic [12:0] m_lfsr;
  int          m_idx;
  logic [1:0]  m_y, m_pmode;
  logic        m_pend, m_lsb, m_mark;
  logic        m_hist [0:MAXS];

  pam4_pattern_encoder uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sym_en(sym_en), .pat_sel(pat_sel),
    .gray_en(gray_en), .precode_en(precode_en), .inv_msb(inv_msb), .inv_lsb(inv_lsb),
    .inv_late(inv_late), .err_req(err_req), .err_mode(err_mode), .skew(skew),
    .out_msb(out_msb), .out_lsb(out_lsb), .err_mark(err_mark)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] gray_tbl(input logic [1:0] p);
    case (p)
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      2'b11: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic int pat_len(input int sel);
    case (sel)
      1: return 2;
      2: return 62;
      3: return 16;
      4: return 160;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] fixed_val(input int sel, input int i);
    int stair [10] = '{0, 1, 2, 3, 0, 3, 0, 3, 2, 1};
    case (sel)
      1: return (i % 2) ? 2'd3 : 2'd0;
      2: if (i < 30) return (i % 2) ? 2'd3 : 2'd0;
         else        return (i % 2) ? 2'd0 : 2'd3;
      3: return (i < 8) ? 2'd3 : 2'd0;
      default: return 2'(stair[i / 16]);
    endcase
  endfunction

  function automatic logic next_bit(input logic [12:0] s);
    return s[0] ^ s[1] ^ s[11] ^ s[12];
  endfunction

  task automatic model_reset();
    m_lfsr = '1; m_idx = 0; m_y = 0; m_pmode = 0; m_pend = 0; m_lsb = 0; m_mark = 0;
    for (int k = 0; k <= MAXS; k++) m_hist[k] = 1'b0;
  endtask

  task automatic model_step();
    logic arm, p, b0, b1;
    logic [1:0] pm, v;
    int sel;
    if (!rst_n) begin
      model_reset();
      return;
    end
    if (restart) begin
      m_lfsr = '1; m_idx = 0; m_y = 0; m_pend = 0;
      return;
    end
    arm = err_req && (err_mode != 2'b00);
    p   = m_pend || arm;
    pm  = arm ? err_mode : m_pmode;
    if (sym_en) begin
      sel = int'(pat_sel);
      if (sel >= 1 && sel <= 4) begin
        v = fixed_val(sel, m_idx);
        m_idx = (m_idx + 1 >= pat_len(sel)) ? 0 : m_idx + 1;
      end else begin
        b0 = next_bit(m_lfsr); m_lfsr = {m_lfsr[11:0], b0};
        b1 = next_bit(m_lfsr); m_lfsr = {m_lfsr[11:0], b1};
        v = {b0, b1};
      end
      if (!inv_late) v = v ^ {inv_msb, inv_lsb};
      if (gray_en)   v = gray_tbl(v);
      if (inv_late)  v = v ^ {inv_msb, inv_lsb};
      if (precode_en) begin
        v = 2'((v - m_y) & 2'b11);
        m_y = v;
      end
      if (p) v = v ^ pm;
      m_mark = p;
      m_pend = 1'b0;
      for (int k = MAXS; k >= 1; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = v[1];
      m_lsb = v[0];
    end else begin
      m_pend  = p;
      m_pmode = pm;
    end
  endtask

  task automatic check_out(input string tag);
    int sk;
    logic [2:0] exp_v, act_v;
    sk = (int'(skew) > MAXS) ? MAXS : int'(skew);
    exp_v = {m_hist[sk], m_lsb, m_mark};
    act_v = {out_msb, out_lsb, err_mark};
    ncheck++;
    if (act_v !== exp_v) begin
      nfail++;
      $display("FAIL %s t=%0t {msb,lsb,mark} actual=%b expected=%b", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic g, input logic pc,
                     input logic im, input logic il, input logic late);
    pat_sel = sel; gray_en = g; precode_en = pc; inv_msb = im; inv_lsb = il; inv_late = late;
    restart = 1'b1; sym_en = 1'b1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(tag);
      restart = 1'b0; err_req = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    ncheck++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; restart = 0; sym_en = 0; pat_sel = 0; gray_en = 0; precode_en = 0;
    inv_msb = 0; inv_lsb = 0; inv_late = 0; err_req = 0; err_mode = 0; skew = 0;
    model_reset();
    // R1: reset state, also with enable pushed during reset
    sym_en = 1'b1;
    run(3, "R1");
    sym_en = 1'b0;
    rst_n = 1'b1;
    run(2, "R1");

    // R3: bit stream source
    cfg(3'd0, 0, 0, 0, 0, 0); run(60, "R3");
    cfg(3'd6, 0, 0, 0, 0, 0); run(20, "R3");
    // R4: pair and square
    cfg(3'd1, 0, 0, 0, 0, 0); run(12, "R4");
    cfg(3'd3, 0, 0, 0, 0, 0); run(40, "R4");
    // R5: even-odd period, two full periods
    cfg(3'd2, 0, 0, 0, 0, 0); run(130, "R5");
    // R6: staircase, full period plus wrap
    cfg(3'd4, 0, 0, 0, 0, 0); run(180, "R6");
    // R7: Gray coder over all levels
    cfg(3'd4, 1, 0, 0, 0, 0); run(170, "R7");
    // R8: inversion placement
    cfg(3'd4, 1, 0, 1, 0, 0); run(64, "R8");
    cfg(3'd4, 1, 0, 1, 0, 1); run(64, "R8");
    cfg(3'd0, 1, 0, 0, 1, 0); run(30, "R8");
    cfg(3'd0, 1, 0, 1, 1, 1); run(30, "R8");
    // R9: precoder, with a restart in the middle
    cfg(3'd0, 0, 1, 0, 0, 0); run(40, "R9");
    restart = 1'b1; run(20, "R9");
    cfg(3'd4, 1, 1, 0, 0, 0); run(40, "R9");
    precode_en = 1'b0; run(5, "R9");
    precode_en = 1'b1; run(5, "R9");

    // R10/R11: error arming
    cfg(3'd3, 0, 1, 0, 0, 0); run(4, "R10");
    err_req = 1; err_mode = 2'b01; run(2, "R10");
    err_req = 1; err_mode = 2'b10; run(2, "R10");
    err_req = 1; err_mode = 2'b11; run(2, "R11");
    sym_en = 0; err_req = 1; err_mode = 2'b01; run(3, "R10");
    err_req = 1; err_mode = 2'b10; run(1, "R10");
    sym_en = 1; run(3, "R11");
    err_req = 1; err_mode = 2'b00; run(3, "R10");
    sym_en = 0; err_req = 1; err_mode = 2'b11; run(1, "R10");
    restart = 1; run(1, "R2");
    sym_en = 1; run(3, "R11");

    // R2: sparse enable and restart priority
    cfg(3'd2, 0, 0, 0, 0, 0);
    for (int i = 0; i < 200; i++) begin
      sym_en = ($urandom % 3) != 0;
      restart = ($urandom % 23) == 0;
      tick("R2");
    end
    restart = 0;

    // R12: skew sweep, including clamp values
    cfg(3'd0, 0, 0, 0, 0, 0); run(12, "R12");
    for (int s = 0; s < 16; s++) begin
      skew = SW'(s);
      run(6, "R12");
    end
    sym_en = 0; skew = 4'd3; run(3, "R12");
    sym_en = 1; skew = 4'd15; run(4, "R12");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      restart = ($urandom % 40) == 0;
      if (restart) pat_sel = 3'($urandom % 8);
      if (($urandom % 25) == 0) begin
        gray_en = 1'($urandom); precode_en = 1'($urandom); inv_msb = 1'($urandom);
        inv_lsb = 1'($urandom); inv_late = 1'($urandom);
      end
      sym_en = ($urandom % 4) != 0;
      err_req = ($urandom % 9) == 0;
      err_mode = 2'($urandom);
      if (($urandom % 15) == 0) skew = SW'($urandom);
      tick("RND");
    end
    restart = 0; err_req = 0;

    summary();
    $finish;
  end

endmodule